// File: doc/BRIEF.md
# Programmable Clock Post-Divider with Phase Output

This block divides a fast input clock by a programmable ratio and produces two waveforms. The first, `div_out`, is the divided clock. The second, `ph_out`, is a copy of that divided clock that can be delayed by zero to three input cycles, inverted, or held low. Both outputs come straight from flip-flops. They are meant to drive a clock-enable network or a clock buffer next to the divider.

The ratio comes from a 5-bit select, `div_sel`. Values 1 to 31 divide by that value, and 0 selects the largest ratio, 32. A new select takes effect only where the current output period ends, so a ratio change never leaves a shortened pulse. The phase controls (`ph_en`, `ph_inv`, `ph_dly`) may change at any time, and they act on the output that follows the next clock edge. At divide-by-1 the divided waveform is constantly high. In that mode the delay is treated as 0 and the invert control is ignored, so the phase copy simply follows the main output. A `running` flag goes high once the divider has left reset.

Every input is sampled on the rising edge of `clk`. A change that is sampled at edge k shows on the outputs right after edge k.

Top module: `postdiv_phase`

## Requirements
- R1: While `rst` is high, `div_out` and `ph_out` are 1. After `rst` is released, the divider runs with ratio 16 until it reaches its first period boundary.
- R2: With `div_sel` = s held steady, `div_out` repeats every N input cycles, where N = s for s in 1..31 and N = 32 for s = 0.
- R3: Each output period starts with `div_out` high for ceil(N/2) cycles, followed by ceil(N/2)... low for floor(N/2) cycles. At N = 1, `div_out` stays at 1.
- R4: A change of `div_sel` in the middle of a period does not alter that period. The new ratio starts with the first cycle of the next period.
- R5: When `ph_en` = 1 and N ≠ 1, `ph_out` equals `div_out` from `ph_dly` cycles earlier (0..3), XOR `ph_inv`. A new `ph_dly` acts from the next cycle, and the history used for it runs continuously.
- R6: When N ≠ 1, `ph_inv` = 1 inverts `ph_out` relative to the delayed main output.
- R7: When N = 1, `ph_inv` and `ph_dly` have no effect, and `ph_out` equals `ph_en`.
- R8: When `ph_en` = 0 is sampled at an edge, `ph_out` is 0 after that edge.
- R9: `running` is 0 while `rst` is high. It is 1 from the first clock edge after `rst` is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous active-high reset |
| div_sel | input | 5 | Divide select; 0 means 32 |
| ph_en | input | 1 | Phase output enable |
| ph_inv | input | 1 | Phase output invert (ignored at N = 1) |
| ph_dly | input | 2 | Phase delay in input cycles (forced to 0 at N = 1) |
| div_out | output | 1 | Divided clock |
| ph_out | output | 1 | Delayed / inverted / gated copy of the divided clock |
| running | output | 1 | Divider active flag |

## Verification
The bench runs the odd ratios, where a design that rounded the high time the wrong way would show a 2/3 duty at N = 5 instead of 3/2. It also runs the 0-means-32 encoding, where a plain truncation would divide by zero or by 1. Ratio changes are made in the middle of a period. A design that loaded the new ratio at once would cut the current pulse short or stretch it, and the per-cycle compare would catch the runt. At divide-by-1 the bench applies invert and the largest delay together. A design that did not override them would produce a constant 0, or would replay stale history from the previous ratio.

// File: rtl/postdiv_pkg.sv
package postdiv_pkg;
  localparam int unsigned SEL_W   = 5;
  localparam int unsigned DLY_W   = 2;
  localparam int unsigned RST_DIV = 16;

  typedef struct packed {
    logic             en;
    logic             inv;
    logic [DLY_W-1:0] dly;
  } ph_ctrl_t;
endpackage

// File: rtl/pdiv_counter.sv
module pdiv_counter #(
  parameter int unsigned SEL_W   = 5,
  parameter int unsigned RST_DIV = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [SEL_W-1:0]   div_sel,
  output logic [SEL_W-1:0]   cnt_q,
  output logic [SEL_W:0]     n_q,
  output logic [SEL_W:0]     n_nxt,
  output logic               div_nxt,
  output logic               div_q
);
  localparam int unsigned N_W = SEL_W + 1;

  logic [N_W-1:0]   n_sel;
  logic             wrap;
  logic [SEL_W-1:0] cnt_nxt;
  logic [N_W:0]     hi_len;

  always_comb begin
    n_sel   = (div_sel == '0) ? N_W'(1 << SEL_W) : {1'b0, div_sel};
    wrap    = ({1'b0, cnt_q} == (n_q - N_W'(1)));
    n_nxt   = wrap ? n_sel : n_q;
    cnt_nxt = wrap ? '0 : (cnt_q + SEL_W'(1));
    hi_len  = ({1'b0, n_nxt} + (N_W+1)'(1)) >> 1;
    div_nxt = ({2'b00, cnt_nxt} < hi_len);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      n_q   <= N_W'(RST_DIV);
      div_q <= 1'b1;
    end else begin
      cnt_q <= cnt_nxt;
      n_q   <= n_nxt;
      div_q <= div_nxt;
    end
  end
endmodule

// File: rtl/pdiv_phase.sv
module pdiv_phase
  import postdiv_pkg::*;
#(
  parameter int unsigned DLY_W = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     div_nxt,
  input  logic     div_q,
  input  logic     unity,
  input  ph_ctrl_t ctrl,
  output logic     ph_q
);
  localparam int unsigned DEPTH  = 1 << DLY_W;
  localparam int unsigned LINE_N = DEPTH - 2;

  logic [LINE_N-1:0] line_q;
  logic [DEPTH-1:0]  taps;
  logic [DLY_W-1:0]  shift;
  logic              pick;
  logic              ph_d;

  for (genvar i = 0; i < LINE_N; i++) begin : g_line
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) line_q[i] <= 1'b1;
        else     line_q[i] <= div_q;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst) line_q[i] <= 1'b1;
        else     line_q[i] <= line_q[i-1];
      end
    end
  end

  always_comb begin
    taps  = {line_q, div_q, div_nxt};
    shift = unity ? '0 : ctrl.dly;
    pick  = taps[shift];
    ph_d  = ctrl.en & (pick ^ (ctrl.inv & ~unity));
  end

  always_ff @(posedge clk) begin
    if (rst) ph_q <= 1'b1;
    else     ph_q <= ph_d;
  end
endmodule

// File: rtl/postdiv_phase.sv
module postdiv_phase
  import postdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] div_sel,
  input  logic             ph_en,
  input  logic             ph_inv,
  input  logic [DLY_W-1:0] ph_dly,
  output logic             div_out,
  output logic             ph_out,
  output logic             running
);
  logic [SEL_W-1:0] cnt_q;
  logic [SEL_W:0]   n_q;
  logic [SEL_W:0]   n_nxt;
  logic             div_nxt;
  logic             div_q;
  logic             unity;
  ph_ctrl_t         ctrl;
  logic             run_q;

  pdiv_counter #(.SEL_W(SEL_W), .RST_DIV(RST_DIV)) u_cnt (
    .clk(clk), .rst(rst), .div_sel(div_sel),
    .cnt_q(cnt_q), .n_q(n_q), .n_nxt(n_nxt),
    .div_nxt(div_nxt), .div_q(div_q)
  );

  assign unity = (n_nxt == (SEL_W+1)'(1));
  assign ctrl  = '{en: ph_en, inv: ph_inv, dly: ph_dly};

  pdiv_phase #(.DLY_W(DLY_W)) u_ph (
    .clk(clk), .rst(rst), .div_nxt(div_nxt), .div_q(div_q),
    .unity(unity), .ctrl(ctrl), .ph_q(ph_out)
  );

  always_ff @(posedge clk) begin
    if (rst) run_q <= 1'b0;
    else     run_q <= 1'b1;
  end

  assign div_out = div_q;
  assign running = run_q;
endmodule

// File: rtl/postdiv_phase_chk.sv
module postdiv_phase_chk #(
  parameter int unsigned SEL_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             ph_en,
  input logic             div_out,
  input logic             ph_out,
  input logic             running,
  input logic [SEL_W-1:0] cnt_q,
  input logic [SEL_W:0]   n_q,
  input logic [SEL_W:0]   n_nxt
);
  AST_RST_IDLE: assert property (@(posedge clk) rst |=> !running); // R9
  AST_RUN_SET: assert property (@(posedge clk) disable iff (rst) !rst |=> running); // R9
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst) ({1'b0, cnt_q} < n_q)); // R2
  AST_N_HOLD: assert property (@(posedge clk) disable iff (rst) (cnt_q != '0) |-> $stable(n_q)); // R4
  AST_PH_GATE: assert property (@(posedge clk) disable iff (rst) !ph_en |=> !ph_out); // R8
  AST_UNITY_PH: assert property (@(posedge clk) disable iff (rst) (ph_en && n_nxt == (SEL_W+1)'(1)) |=> ph_out); // R7
  AST_UNITY_DIV: assert property (@(posedge clk) disable iff (rst) (n_nxt == (SEL_W+1)'(1)) |=> div_out); // R3
endmodule

bind postdiv_phase postdiv_phase_chk #(.SEL_W(postdiv_pkg::SEL_W)) u_chk (
  .clk(clk), .rst(rst), .ph_en(ph_en), .div_out(div_out), .ph_out(ph_out),
  .running(running), .cnt_q(cnt_q), .n_q(n_q), .n_nxt(n_nxt)
);

// File: tb/postdiv_phase_test.sv
`timescale 1ns/1ps
module postdiv_phase_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] div_sel = 5'd16;
  logic       ph_en = 1'b1;
  logic       ph_inv = 1'b0;
  logic [1:0] ph_dly = 2'd0;
  logic       div_out, ph_out, running;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit started = 0;
  string cur_req = "R1";

  // behavioural reference
  int m_pos, m_n;
  bit m_div, m_ph, m_run;
  bit m_hist[$];

  always #2 clk = ~clk;

  postdiv_phase uut (
    .clk(clk), .rst(rst), .div_sel(div_sel), .ph_en(ph_en), .ph_inv(ph_inv),
    .ph_dly(ph_dly), .div_out(div_out), .ph_out(ph_out), .running(running)
  );

  task automatic check(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    int sh;
    started = 1;
    cycles++;
    if (rst) begin
      m_pos = 0; m_n = 16; m_div = 1; m_ph = 1; m_run = 0;
      m_hist = '{1, 1, 1, 1};
    end else begin
      if (m_pos == m_n - 1) begin
        m_pos = 0;
        m_n = (div_sel == 0) ? 32 : int'(div_sel);
      end else m_pos++;
      m_div = (m_pos < (m_n + 1) / 2);
      m_hist.push_front(m_div);
      while (m_hist.size() > 4) void'(m_hist.pop_back());
      sh = (m_n == 1) ? 0 : int'(ph_dly);
      m_ph = ph_en ? (m_hist[sh] ^ (ph_inv && m_n != 1)) : 1'b0;
      m_run = 1;
    end
  end

  always @(negedge clk) begin
    if (started) begin
      check(cur_req, "div_out", div_out, m_div);
      check(cur_req, "ph_out", ph_out, m_ph);
      check("R9", "running", running, m_run);
    end
  end

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic finish_up();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    run(3);
    @(negedge clk);
    check("R1", "reset div_out", div_out, 1);
    check("R1", "reset ph_out", ph_out, 1);
    check("R9", "reset running", running, 0);
    @(posedge clk); #1;
    rst = 0;
    cur_req = "R1"; run(20);
    cur_req = "R2"; div_sel = 5'd5;  run(60);
    div_sel = 5'd0;  run(100);
    div_sel = 5'd31; run(80);
    div_sel = 5'd2;  run(20);
    cur_req = "R3"; div_sel = 5'd5; run(12);
    begin
      int hi, lo;
      hi = 0; lo = 0;
      while (div_out !== 1'b0) begin @(posedge clk); #1; end
      while (div_out !== 1'b1) begin @(posedge clk); #1; end
      while (div_out === 1'b1) begin hi++; @(posedge clk); #1; end
      while (div_out === 1'b0) begin lo++; @(posedge clk); #1; end
      check("R3", "high cycles N=5", hi, 3);
      check("R3", "low cycles N=5", lo, 2);
    end
    div_sel = 5'd3; run(30);
    cur_req = "R4"; div_sel = 5'd8; run(11);
    div_sel = 5'd3; run(2); div_sel = 5'd9; run(3); div_sel = 5'd4; run(40);
    cur_req = "R5"; div_sel = 5'd7;
    for (int d = 0; d < 4; d++) begin ph_dly = 2'(d); run(25); end
    for (int i = 0; i < 300; i++) begin
      ph_dly = 2'($urandom_range(0, 3));
      if ((i % 37) == 0) div_sel = 5'($urandom_range(2, 12));
      run(1);
    end
    cur_req = "R6"; ph_inv = 1; div_sel = 5'd6;
    for (int d = 0; d < 4; d++) begin ph_dly = 2'(d); run(20); end
    cur_req = "R7"; div_sel = 5'd1; ph_dly = 2'd3; run(30);
    @(negedge clk);
    check("R7", "unity ph_out", ph_out, 1);
    check("R7", "unity div_out", div_out, 1);
    ph_inv = 0; ph_dly = 2'd2; run(10);
    cur_req = "R8"; ph_en = 0; div_sel = 5'd4; run(30);
    @(negedge clk);
    check("R8", "gated ph_out", ph_out, 0);
    ph_en = 1; ph_inv = 1; run(20);
    cur_req = "R1"; rst = 1; run(3);
    @(negedge clk);
    check("R1", "re-reset div_out", div_out, 1);
    check("R9", "re-reset running", running, 0);
    rst = 0; ph_inv = 0; div_sel = 5'd16; run(40);
    finish_up();
  end

  initial begin
    #400000;
    tests++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 0);
    finish_up();
  end
endmodule